// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models the status logic a NOR-style flash device presents while an internal program or erase operation runs. A command interface starts a byte program, a sector erase or a chip erase, or aborts everything with a reset command. While an operation is busy, each read strobe returns a status byte instead of array data. One bit flips on every read. A second bit flips only when the read addresses a sector chosen for erase. A third bit raises a timeout flag, and a fourth shows whether the sector-erase collection window has closed. Bit 7 carries the complement of the data being programmed.

Progress is counted in internal pulses, each one a single-cycle `pulse_en` strobe. A program attempt that would need to turn a 0 cell back into 1 never finishes. It keeps pulsing until the limit is reached and then stays in a timeout state until a reset command arrives. The cell contents the program applies to are supplied by the surrounding array on `cell_data`. When idle, reads return a held array word. This word starts at a parameter value and becomes the programmed byte or 0xFF after a successful operation.

Top module: `fsg_status_gen`

## Requirements
- R1: While busy, bit 6 of each read result is the inverse of bit 6 of the previous busy read. Idle reads return the array word and do not change the toggle state.
- R2: During a sector or chip erase, bit 2 inverts only on reads whose `rd_sector` is selected for erase. On other reads, and during program, bit 2 holds its value.
- R3: A program whose `cmd_data` has a 1 where `cell_data` has a 0 stays busy with bit 5 at 0 for MAX_PULSES-1 pulses. The next pulse sets bit 5 to 1, and bit 6 keeps toggling.
- R4: In the timeout state, program and erase commands are ignored. Reads keep returning the timeout status.
- R5: A reset command (`cmd_op`=3) returns the block to idle from any state. The array word is left unchanged.
- R6: A valid program (`cmd_op`=0) clears `busy` on its PROG_PULSES-th pulse. While busy, bit 7 equals the inverse of `cmd_data[7]`. Later idle reads return `cmd_data`.
- R7: After a sector erase command (`cmd_op`=1), bit 3 reads 0 for the next WINDOW_CYCLES clock edges and 1 afterwards. A further sector erase inside the window adds its sector and restarts the window.
- R8: A chip erase (`cmd_op`=2) selects all sectors and shows bit 3 = 1 and bit 7 = 0 at once. It clears `busy` on its ERASE_PULSES-th pulse, and idle reads then return 0xFF.
- R9: Pulses arriving while the erase window is open are not counted toward the erase.
- R10: After `rst_n`, `busy` is 0, `rd_data` is 0, and an idle read returns IDLE_WORD.
- R11: Status bits 4, 1 and 0 read 0 while busy.
- R12: While a program or erase is running (window closed), program and erase commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reset |
| cmd_sector | input | SECT_W | Sector for sector erase |
| cmd_data | input | 8 | Byte to program |
| cell_data | input | 8 | Present contents of the target cell |
| pulse_en | input | 1 | One internal program/erase pulse |
| rd_en | input | 1 | Read strobe |
| rd_sector | input | SECT_W | Sector addressed by the read |
| rd_data | output | 8 | Registered read result |
| busy | output | 1 | An operation or timeout state is active |

## Verification
A wrong state register shows up on the first read that follows. The bit 3 window flag, the bit 5 timeout flag and bit 7 sit directly on the next `rd_data`. A pulse-count or window-length error moves the edge where `busy` falls or bit 3 rises by one or more cycles, and the bench probes each side of those edges. A bad selection mask or toggle register is exposed by the second read of a busy pair, because bit 6 or bit 2 then fails to invert against the bench's own toggle tracking.

// File: rtl/fsg_pkg.sv
// Shared types for the flash status generator.
// Assumes an 8-bit status byte with the bit positions below.
package fsg_pkg;
    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SERASE = 2'd1,
        OP_CERASE = 2'd2,
        OP_RESET  = 2'd3
    } fsg_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PROG = 3'd1,
        ST_EWIN = 3'd2,
        ST_ERUN = 3'd3,
        ST_FAIL = 3'd4
    } fsg_state_e;

    localparam int BIT_POLL = 7;
    localparam int BIT_TOG  = 6;
    localparam int BIT_TMO  = 5;
    localparam int BIT_WIN  = 3;
    localparam int BIT_SEL  = 2;
endpackage

// File: rtl/fsg_pulse_ctr.sv
// Counts internal operation pulses.
// Assumes the owner clears it whenever no operation is counting.
module fsg_pulse_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Pulse count register with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fsg_win_timer.sv
// Down-counter for the sector-erase collection window.
// A load restarts the full window and expiry is flagged while running.
module fsg_win_timer #(
    parameter int WINDOW_CYCLES = 5,
    localparam int TW = $clog2(WINDOW_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam logic [TW-1:0] RELOAD = TW'(WINDOW_CYCLES - 1);
    logic [TW-1:0] remain_q;

    // Window countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= RELOAD;
        end else if (run && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = run && !load && (remain_q == '0);
endmodule

// File: rtl/fsg_toggle_unit.sv
// Holds the two read-triggered toggle bits.
// Both bits change only on reads made while busy.
module fsg_toggle_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic busy,
    input  logic sel_hit,
    output logic tog_all,
    output logic tog_sel
);
    // Toggle state: the all-reads bit and the selected-sector bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_all <= 1'b0;
            tog_sel <= 1'b0;
        end else if (rd_en && busy) begin
            tog_all <= ~tog_all;
            if (sel_hit) begin
                tog_sel <= ~tog_sel;
            end
        end
    end
endmodule

// File: rtl/fsg_status_gen.sv
// Flash embedded-operation status generator (top).
// Sequences program, sector erase and chip erase, and builds the
// status byte returned on each read while busy. Assumes pulse_en is
// a single-cycle strobe and cell_data is valid with a program command.
module fsg_status_gen
    import fsg_pkg::*;
#(
    parameter int         NUM_SECTORS   = 8,
    parameter int         PROG_PULSES   = 4,
    parameter int         ERASE_PULSES  = 6,
    parameter int         MAX_PULSES    = 12,
    parameter int         WINDOW_CYCLES = 5,
    parameter logic [7:0] IDLE_WORD     = 8'hA5,
    localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
    localparam int CNT_W  = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [SECT_W-1:0] cmd_sector,
    input  logic [7:0]        cmd_data,
    input  logic [7:0]        cell_data,
    input  logic              pulse_en,
    input  logic              rd_en,
    input  logic [SECT_W-1:0] rd_sector,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_PULSES - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_PULSES - 1);
    localparam logic [CNT_W-1:0] FAIL_LAST  = CNT_W'(MAX_PULSES - 1);

    fsg_state_e             state_q;
    fsg_op_e                op;
    logic [NUM_SECTORS-1:0] sel_mask_q;
    logic [NUM_SECTORS-1:0] cmd_onehot;
    logic [7:0]             pdata_q;
    logic [7:0]             array_q;
    logic                   bad_q;
    logic [CNT_W-1:0]       pcount;
    logic                   win_expired;
    logic                   tog_all;
    logic                   tog_sel;
    logic                   erasing;
    logic                   sel_hit;
    logic                   do_reset;
    logic                   win_load;
    logic [7:0]             status;

    assign op       = fsg_op_e'(cmd_op);
    assign do_reset = cmd_valid && (op == OP_RESET);
    assign busy     = (state_q != ST_IDLE);
    assign erasing  = (state_q == ST_EWIN) || (state_q == ST_ERUN);
    assign sel_hit  = erasing && sel_mask_q[rd_sector];
    assign win_load = cmd_valid && (op == OP_SERASE) &&
                      ((state_q == ST_IDLE) || (state_q == ST_EWIN));

    // One-hot decode of the commanded sector.
    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_onehot
        assign cmd_onehot[s] = (cmd_sector == SECT_W'(s));
    end

    fsg_pulse_ctr #(.CNT_W(CNT_W)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state_q == ST_IDLE) || (state_q == ST_EWIN)),
        .inc   (pulse_en && ((state_q == ST_PROG) || (state_q == ST_ERUN))),
        .count (pcount)
    );

    fsg_win_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (win_load),
        .run     (state_q == ST_EWIN),
        .expired (win_expired)
    );

    fsg_toggle_unit u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .busy    (busy),
        .sel_hit (sel_hit),
        .tog_all (tog_all),
        .tog_sel (tog_sel)
    );

    // Operation sequencer: command acceptance, completion and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sel_mask_q <= '0;
            pdata_q    <= '0;
            bad_q      <= 1'b0;
            array_q    <= IDLE_WORD;
        end else if (do_reset) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid && op == OP_PROG) begin
                        state_q <= ST_PROG;
                        pdata_q <= cmd_data;
                        bad_q   <= |(cmd_data & ~cell_data);
                    end else if (cmd_valid && op == OP_SERASE) begin
                        state_q    <= ST_EWIN;
                        sel_mask_q <= cmd_onehot;
                    end else if (cmd_valid && op == OP_CERASE) begin
                        state_q    <= ST_ERUN;
                        sel_mask_q <= '1;
                    end
                end
                ST_PROG: begin
                    if (pulse_en && !bad_q && pcount == PROG_LAST) begin
                        state_q <= ST_IDLE;
                        array_q <= pdata_q;
                    end else if (pulse_en && bad_q && pcount == FAIL_LAST) begin
                        state_q <= ST_FAIL;
                    end
                end
                ST_EWIN: begin
                    if (cmd_valid && op == OP_SERASE) begin
                        sel_mask_q <= sel_mask_q | cmd_onehot;
                    end else if (win_expired) begin
                        state_q <= ST_ERUN;
                    end
                end
                ST_ERUN: begin
                    if (pulse_en && pcount == ERASE_LAST) begin
                        state_q <= ST_IDLE;
                        array_q <= 8'hFF;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // Status byte assembly for busy reads.
    always_comb begin
        status           = '0;
        status[BIT_POLL] = ((state_q == ST_PROG) || (state_q == ST_FAIL)) ?
                           ~pdata_q[7] : 1'b0;
        status[BIT_TOG]  = tog_all;
        status[BIT_TMO]  = (state_q == ST_FAIL);
        status[BIT_WIN]  = (state_q == ST_ERUN);
        status[BIT_SEL]  = tog_sel;
    end

    // Registered read port: status while busy, array word when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= busy ? status : array_q;
        end
    end
endmodule

// File: rtl/fsg_status_chk.sv
// Property checker for fsg_status_gen, bound to every instance.
module fsg_status_chk
    import fsg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       busy,
    input logic [7:0] rd_data,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [2:0] state_q
);
    logic rd_q;
    logic busy_rd_q;
    logic prev_valid;
    logic prev_tog;

    // Track bit 6 of the last read taken while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q       <= 1'b0;
            busy_rd_q  <= 1'b0;
            prev_valid <= 1'b0;
            prev_tog   <= 1'b0;
        end else begin
            rd_q      <= rd_en;
            busy_rd_q <= rd_en && busy;
            if (rd_q && busy_rd_q) begin
                prev_tog   <= rd_data[BIT_TOG];
                prev_valid <= 1'b1;
            end
        end
    end

    assert_toggle_flips_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && busy_rd_q && prev_valid) |-> (rd_data[BIT_TOG] != prev_tog));

    assert_fail_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIL && !(cmd_valid && cmd_op == OP_RESET)) |=> (state_q == ST_FAIL));

    assert_no_timeout_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && state_q != ST_FAIL) |=> !rd_data[BIT_TMO]);

    assert_window_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && state_q == ST_EWIN) |=> !rd_data[BIT_WIN]);

    assert_erase_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && state_q == ST_ERUN) |=> rd_data[BIT_WIN]);

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));

    assert_reset_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RESET) |=> !busy);
endmodule

bind fsg_status_gen fsg_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .busy      (busy),
    .rd_data   (rd_data),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .state_q   (state_q)
);

// File: tb/fsg_status_gen_tb.sv
module fsg_status_gen_tb;
    localparam int SECT_W = 3;
    localparam int NSEC   = 8;
    localparam int PROG_N = 4;
    localparam int ERASE_N = 6;
    localparam int MAX_N  = 12;
    localparam int WIN_N  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = '0;
    logic [SECT_W-1:0] cmd_sector = '0;
    logic [7:0]        cmd_data = '0;
    logic [7:0]        cell_data = '0;
    logic              pulse_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [SECT_W-1:0] rd_sector = '0;
    logic [7:0]        rd_data;
    logic              busy;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    bit  et6 = 1'b0;
    bit  et2 = 1'b0;

    always #5 clk = ~clk;

    fsg_status_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sector(cmd_sector), .cmd_data(cmd_data), .cell_data(cell_data),
        .pulse_en(pulse_en), .rd_en(rd_en), .rd_sector(rd_sector),
        .rd_data(rd_data), .busy(busy)
    );

    function automatic logic [7:0] exp_status(bit b7, bit b5, bit b3);
        return {b7, et6, b5, 1'b0, b3, et2, 2'b00};
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic send(logic [1:0] op, int sec, logic [7:0] d, logic [7:0] c);
        cmd_valid = 1'b1; cmd_op = op; cmd_sector = SECT_W'(sec);
        cmd_data = d; cell_data = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            pulse_en = 1'b1;
            @(negedge clk);
            pulse_en = 1'b0;
        end
    endtask

    task automatic do_read(int sec, output logic [7:0] v);
        rd_en = 1'b1; rd_sector = SECT_W'(sec);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic rd_busy(string req, int sec, bit b7, bit b5, bit b3, bit sel);
        logic [7:0] v;
        do_read(sec, v);
        check(req, v, exp_status(b7, b5, b3));
        et6 = ~et6;
        if (sel) et2 = ~et2;
    endtask

    task automatic rd_idle(string req, int sec, logic [7:0] word);
        logic [7:0] v;
        do_read(sec, v);
        check(req, v, word);
    endtask

    task automatic chk_busy(string req, bit exp);
        check(req, {7'd0, busy}, {7'd0, exp});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R1 idle reads do not toggle
        chk_busy("R10", 1'b0);
        check("R10", rd_data, 8'h00);
        rd_idle("R10", 0, 8'hA5);
        rd_idle("R1", 3, 8'hA5);

        // R6 valid program, R12 erase ignored while programming
        send(2'd0, 0, 8'h3C, 8'hFF);
        rd_busy("R6", 0, 1'b1, 1'b0, 1'b0, 1'b0);
        rd_busy("R1", 4, 1'b1, 1'b0, 1'b0, 1'b0);
        pulse(PROG_N - 1);
        send(2'd2, 0, 8'h00, 8'h00);
        rd_busy("R12", 1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk_busy("R6", 1'b1);
        pulse(1);
        chk_busy("R6", 1'b0);
        rd_idle("R6", 2, 8'h3C);

        // R8 chip erase with random sector reads, R2 all selected
        send(2'd2, 0, 8'h00, 8'h00);
        for (int i = 0; i < 10; i++) begin
            rd_busy("R2", $urandom_range(NSEC - 1), 1'b0, 1'b0, 1'b1, 1'b1);
        end
        pulse(ERASE_N - 1);
        chk_busy("R8", 1'b1);
        pulse(1);
        chk_busy("R8", 1'b0);
        rd_idle("R8", 0, 8'hFF);

        // R7 window and restart, R9 pulses ignored in window, R2 selection
        send(2'd1, 2, 8'h00, 8'h00);
        rd_busy("R7", 2, 1'b0, 1'b0, 1'b0, 1'b1);
        rd_busy("R2", 5, 1'b0, 1'b0, 1'b0, 1'b0);
        send(2'd1, 5, 8'h00, 8'h00);
        rd_busy("R7", 5, 1'b0, 1'b0, 1'b0, 1'b1);
        pulse(2);
        repeat (WIN_N - 4) @(negedge clk);
        rd_busy("R7", 1, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_busy("R7", 2, 1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            int s = $urandom_range(NSEC - 1);
            rd_busy("R2", s, 1'b0, 1'b0, 1'b1, (s == 2) || (s == 5));
        end
        pulse(ERASE_N - 1);
        chk_busy("R9", 1'b1);
        pulse(1);
        chk_busy("R9", 1'b0);
        rd_idle("R8", 5, 8'hFF);

        // R3 program 0 -> 1 times out, R4 commands ignored, R5 reset
        send(2'd0, 0, 8'h1F, 8'h0F);
        rd_busy("R3", 0, 1'b1, 1'b0, 1'b0, 1'b0);
        pulse(MAX_N - 1);
        rd_busy("R3", 0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk_busy("R3", 1'b1);
        pulse(1);
        rd_busy("R3", 0, 1'b1, 1'b1, 1'b0, 1'b0);
        rd_busy("R3", 6, 1'b1, 1'b1, 1'b0, 1'b0);
        send(2'd2, 0, 8'h00, 8'h00);
        send(2'd0, 0, 8'h00, 8'hFF);
        rd_busy("R4", 0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk_busy("R4", 1'b1);
        send(2'd3, 0, 8'h00, 8'h00);
        chk_busy("R5", 1'b0);
        rd_idle("R5", 0, 8'hFF);

        // R5 reset inside the erase window
        send(2'd1, 1, 8'h00, 8'h00);
        rd_busy("R7", 1, 1'b0, 1'b0, 1'b0, 1'b1);
        send(2'd3, 0, 8'h00, 8'h00);
        chk_busy("R5", 1'b0);
        rd_idle("R5", 1, 8'hFF);

        // R6 random valid programs on erased cells, R11 via status compares
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d = 8'($urandom);
            send(2'd0, 0, d, 8'hFF);
            rd_busy("R11", $urandom_range(NSEC - 1), ~d[7], 1'b0, 1'b0, 1'b0);
            pulse(PROG_N);
            chk_busy("R6", 1'b0);
            rd_idle("R6", 0, d);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule